// File: doc/BRIEF.md
# Line Readout Pixel Sequencer

This block sits between an external ADC and the downstream image path of a line sensor that reads out 516 pixels per line. It works in the pixel clock domain. The sensor's acquisition period input (`period_i`) is high while a line may be read. A rising edge on the start input (`start_i`) arms the readout. The sample gate input (`gate_i`) ends the read window when it falls. The ADC delivers one word per accepted sample on `smp_i`, qualified by `smp_vld_i`. Each pixel gives two consecutive words: the reference level first and the signal level second.

The block keeps count of the physical pixel position. It pairs the two words of each pixel and emits the signal word minus the reference word as a signed value one bit wider than the ADC word, with no clamping. The two redundant pixels at each end of the line are dropped, so only physical pixels 3 through 514 reach the output. Every line restarts at pixel 1; there is no resume from unread pixels. An end-of-line marker comes with pixel 514. A line that ends before that pixel instead produces a marker flagged as short. Samples that arrive after pixel 516, or after the read window has closed, are thrown away.

The controller has three states:
- `LS_IDLE` waits for a start edge.
- `LS_READ` pairs and counts samples.
- `LS_DRAIN` discards samples until the acquisition period ends.

Its transitions are:
- IDLE→READ on a start rising edge while `period_i` is high.
- READ→IDLE when `period_i` falls.
- READ→DRAIN when `gate_i` falls or after the signal word of pixel 516.
- DRAIN→IDLE when `period_i` is low.

Top module: `line_pixel_sequencer`

## Requirements
- R1: A synchronous `rst` clears `pix_vld_o`, `eol_o` and `short_o` to 0 and returns the controller to `LS_IDLE`. After reset, no sample produces output until a new start edge arrives.
- R2: A line starts only at the clock edge where `start_i` is seen high after being low in the previous cycle, and only while `period_i` is high. Samples at that edge or before it are ignored. The first sample taken is the one presented at the next edge.
- R3: Within a line, accepted samples alternate: the even-numbered ones (starting at 0) are reference words and the odd-numbered ones are signal words. A pixel completes on its signal word.
- R4: For a completed pixel, `pix_val_o` equals signal minus reference. The ADC words are treated as unsigned and the result is SMP_W+1 bits two's complement, with no saturation, so +4095 and -4095 both appear at SMP_W=12.
- R5: `pix_vld_o` pulses for one cycle, in the cycle after the edge that takes a signal word, only for physical pixels 3 to 514. `pix_idx_o` gives the 1-based physical index, so one full line gives exactly 512 outputs, indices 3 through 514 in order.
- R6: `eol_o` is high with `short_o` low in exactly the output cycle of pixel 514. This happens once per line, including when the line stops after pixel 514 but before pixel 516.
- R7: If `period_i` falls while in `LS_READ` before pixel 514 has been output, the block emits a single cycle with `eol_o`=1, `short_o`=1 and `pix_vld_o`=0. Any pending reference word is dropped, and the next line starts again at pixel 1.
- R8: A falling edge of `gate_i` while in `LS_READ` ends the read window. If pixel 514 has not yet been output, it gives the same short marker as R7. All samples after that are discarded until `period_i` goes low.
- R9: Once the signal word of pixel 516 has been taken, further samples produce no output until `period_i` goes low.
- R10: Start edges arriving during `LS_READ` or `LS_DRAIN` are ignored. The pixel count neither restarts nor moves backward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| period_i | input | 1 | Acquisition period active (high) |
| start_i | input | 1 | Line start trigger; rising edge arms readout |
| gate_i | input | 1 | Sample gate; falling edge closes the read window |
| smp_vld_i | input | 1 | ADC word valid |
| smp_i | input | SMP_W | ADC word, unsigned |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_idx_o | output | IDX_W | Physical 1-based pixel index |
| pix_val_o | output | SMP_W+1 | Signal minus reference, signed |
| eol_o | output | 1 | End-of-line marker |
| short_o | output | 1 | Marker is for a short (truncated) line |

## Verification
The bench targets four kinds of corner case:
- The edges of the line: the index 2→3 and 514→515 masking boundaries, and lines that stop one pixel before and one pixel after 514. A design off by one there would emit 511 or 513 pixels, or flag a complete line as short.
- Early line endings: the acquisition period ending with a reference word still pending, and the gate falling mid-line. A design that kept the pending word would pair the next line's samples the wrong way round, and one that kept counting after the gate fell would emit pixels from discarded samples.
- Interference: stray start edges during a read, which would restart the index, and a reset in mid-line.
- Extremes of the subtraction: full-scale words in both orders, which expose a missing sign bit or a wrongly placed clamp.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [1:0] {
        LS_IDLE  = 2'd0,
        LS_READ  = 2'd1,
        LS_DRAIN = 2'd2
    } lps_state_e;

endpackage

// File: rtl/lps_edge.sv
// Registered edge detector; RISE selects which transition is reported.
module lps_edge #(
    parameter bit RISE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic hit
);
    logic d_q;

    always_ff @(posedge clk) begin
        if (rst) d_q <= 1'b0;
        else     d_q <= d;
    end

    generate
        if (RISE) begin : g_rise
            assign hit = d & ~d_q;
        end else begin : g_fall
            assign hit = ~d & d_q;
        end
    endgenerate

endmodule

// File: rtl/lps_fsm.sv
// Line controller: tracks state, pixel position and reference/signal phase.
module lps_fsm
    import lps_pkg::*;
#(
    parameter int N_PIX  = 516,
    parameter int N_EDGE = 2,
    parameter int IDX_W  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             period_i,
    input  logic             start_rise,
    input  logic             gate_fall,
    input  logic             smp_vld,
    output lps_state_e       state_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             take_ref,
    output logic             take_sig,
    output logic             short_evt
);
    localparam logic [IDX_W-1:0] ONE      = IDX_W'(1);
    localparam logic [IDX_W-1:0] LAST_PIX = IDX_W'(N_PIX);
    localparam logic [IDX_W-1:0] LAST_OUT = IDX_W'(N_PIX - N_EDGE);

    lps_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             sig_ph_q, sig_ph_d;
    logic             done_q, done_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= LS_IDLE;
            idx_q    <= ONE;
            sig_ph_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            idx_q    <= idx_d;
            sig_ph_q <= sig_ph_d;
            done_q   <= done_d;
        end
    end

    // Next state and strobes
    always_comb begin
        state_d   = state_q;
        idx_d     = idx_q;
        sig_ph_d  = sig_ph_q;
        done_d    = done_q;
        take_ref  = 1'b0;
        take_sig  = 1'b0;
        short_evt = 1'b0;
        unique case (state_q)
            LS_IDLE: begin
                if (start_rise && period_i) begin
                    state_d  = LS_READ;
                    idx_d    = ONE;
                    sig_ph_d = 1'b0;
                    done_d   = 1'b0;
                end
            end
            LS_READ: begin
                if (!period_i) begin
                    state_d   = LS_IDLE;
                    short_evt = !done_q;
                end else if (gate_fall) begin
                    state_d   = LS_DRAIN;
                    short_evt = !done_q;
                end else if (smp_vld) begin
                    if (!sig_ph_q) begin
                        take_ref = 1'b1;
                        sig_ph_d = 1'b1;
                    end else begin
                        take_sig = 1'b1;
                        sig_ph_d = 1'b0;
                        if (idx_q == LAST_OUT) done_d = 1'b1;
                        if (idx_q == LAST_PIX) state_d = LS_DRAIN;
                        else                   idx_d   = idx_q + ONE;
                    end
                end
            end
            LS_DRAIN: begin
                if (!period_i) state_d = LS_IDLE;
            end
            default: state_d = LS_IDLE;
        endcase
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;

    // R2: leaving IDLE needs a start edge
    a_r2_needs_start: assert property (@(posedge clk) disable iff (rst)
        (state_q == LS_IDLE && !start_rise) |=> state_q == LS_IDLE);

    // R10: the position never moves back while a line is being read
    a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state_q == LS_READ && period_i) |=> idx_q >= $past(idx_q));

    // R9: nothing is taken while draining
    a_r9_drain_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == LS_DRAIN) |-> !take_ref && !take_sig);

    // R5: position stays within the physical line
    a_r5_idx_range: assert property (@(posedge clk) disable iff (rst)
        (state_q == LS_READ) |-> (idx_q >= ONE && idx_q <= LAST_PIX));

    // R7: a closed period always returns to IDLE
    a_r7_period_end: assert property (@(posedge clk) disable iff (rst)
        (state_q != LS_IDLE && !period_i) |=> state_q == LS_IDLE);

endmodule

// File: rtl/lps_pair.sv
// Pairs reference and signal words, masks edge pixels, registers outputs.
module lps_pair #(
    parameter int SMP_W  = 12,
    parameter int N_PIX  = 516,
    parameter int N_EDGE = 2,
    parameter int IDX_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    take_ref,
    input  logic                    take_sig,
    input  logic                    short_evt,
    input  logic [IDX_W-1:0]        idx,
    input  logic [SMP_W-1:0]        smp,
    output logic                    pix_vld_o,
    output logic [IDX_W-1:0]        pix_idx_o,
    output logic signed [SMP_W:0]   pix_val_o,
    output logic                    eol_o,
    output logic                    short_o
);
    localparam logic [IDX_W-1:0] FIRST_OUT = IDX_W'(N_EDGE + 1);
    localparam logic [IDX_W-1:0] LAST_OUT  = IDX_W'(N_PIX - N_EDGE);

    logic [SMP_W-1:0]      ref_q;
    logic signed [SMP_W:0] diff;
    logic                  in_band;
    logic                  ref_seen_q;

    assign diff    = $signed({1'b0, smp}) - $signed({1'b0, ref_q});
    assign in_band = (idx >= FIRST_OUT) && (idx <= LAST_OUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q     <= '0;
            pix_vld_o <= 1'b0;
            pix_idx_o <= '0;
            pix_val_o <= '0;
            eol_o     <= 1'b0;
            short_o   <= 1'b0;
        end else begin
            pix_vld_o <= 1'b0;
            eol_o     <= 1'b0;
            short_o   <= 1'b0;
            if (take_ref) ref_q <= smp;
            if (take_sig) begin
                pix_vld_o <= in_band;
                eol_o     <= (idx == LAST_OUT);
                if (in_band) begin
                    pix_idx_o <= idx;
                    pix_val_o <= diff;
                end
            end else if (short_evt) begin
                eol_o   <= 1'b1;
                short_o <= 1'b1;
            end
        end
    end

    // Tracks whether a reference word is pending (for the R3 check)
    always_ff @(posedge clk) begin
        if (rst)                        ref_seen_q <= 1'b0;
        else if (take_ref)              ref_seen_q <= 1'b1;
        else if (take_sig || short_evt) ref_seen_q <= 1'b0;
    end

    // R3: a signal word always follows a reference word
    a_r3_ref_first: assert property (@(posedge clk) disable iff (rst)
        take_sig |-> ref_seen_q);

    // R5: valid outputs only inside the unmasked band
    a_r5_band: assert property (@(posedge clk) disable iff (rst)
        pix_vld_o |-> (pix_idx_o >= FIRST_OUT && pix_idx_o <= LAST_OUT));

    // R6: a normal marker rides on the last unmasked pixel
    a_r6_eol_last: assert property (@(posedge clk) disable iff (rst)
        (eol_o && !short_o) |-> (pix_vld_o && pix_idx_o == LAST_OUT));

    // R7: a short marker stands alone
    a_r7_short_alone: assert property (@(posedge clk) disable iff (rst)
        short_o |-> (eol_o && !pix_vld_o));

    // R4: output value follows the operands one cycle later
    a_r4_value: assert property (@(posedge clk) disable iff (rst)
        take_sig && in_band |=> pix_val_o == $past(diff));

endmodule

// File: rtl/line_pixel_sequencer.sv
module line_pixel_sequencer
    import lps_pkg::*;
#(
    parameter int SMP_W  = 12,
    parameter int N_PIX  = 516,
    parameter int N_EDGE = 2,
    localparam int IDX_W = $clog2(N_PIX + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  period_i,
    input  logic                  start_i,
    input  logic                  gate_i,
    input  logic                  smp_vld_i,
    input  logic [SMP_W-1:0]      smp_i,
    output logic                  pix_vld_o,
    output logic [IDX_W-1:0]      pix_idx_o,
    output logic signed [SMP_W:0] pix_val_o,
    output logic                  eol_o,
    output logic                  short_o
);
    localparam int N_EDGE_DET = 2;
    localparam logic [N_EDGE_DET-1:0] DET_RISE = 2'b01; // bit0 start: rise, bit1 gate: fall

    logic [N_EDGE_DET-1:0] det_in;
    logic [N_EDGE_DET-1:0] det_hit;
    lps_state_e            state;
    logic [IDX_W-1:0]      idx;
    logic                  take_ref, take_sig, short_evt;

    assign det_in = {gate_i, start_i};

    generate
        for (genvar g = 0; g < N_EDGE_DET; g++) begin : g_det
            lps_edge #(.RISE(DET_RISE[g])) u_edge (
                .clk (clk),
                .rst (rst),
                .d   (det_in[g]),
                .hit (det_hit[g])
            );
        end
    endgenerate

    lps_fsm #(.N_PIX(N_PIX), .N_EDGE(N_EDGE), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .period_i   (period_i),
        .start_rise (det_hit[0]),
        .gate_fall  (det_hit[1]),
        .smp_vld    (smp_vld_i),
        .state_o    (state),
        .idx_o      (idx),
        .take_ref   (take_ref),
        .take_sig   (take_sig),
        .short_evt  (short_evt)
    );

    lps_pair #(.SMP_W(SMP_W), .N_PIX(N_PIX), .N_EDGE(N_EDGE), .IDX_W(IDX_W)) u_pair (
        .clk       (clk),
        .rst       (rst),
        .take_ref  (take_ref),
        .take_sig  (take_sig),
        .short_evt (short_evt),
        .idx       (idx),
        .smp       (smp_i),
        .pix_vld_o (pix_vld_o),
        .pix_idx_o (pix_idx_o),
        .pix_val_o (pix_val_o),
        .eol_o     (eol_o),
        .short_o   (short_o)
    );

    // R1: reset leaves the outputs quiet on the next cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!pix_vld_o && !eol_o && !short_o));

    // R1: after reset the controller sits in IDLE
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> state == LS_IDLE);

endmodule

// File: tb/test_line_pixel_sequencer.sv
module test_line_pixel_sequencer;
    localparam int SMP_W = 12;
    localparam int IDX_W = 10;
    localparam int MAXV  = (1 << SMP_W) - 1;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  period_i = 1'b0;
    logic                  start_i = 1'b0;
    logic                  gate_i = 1'b1;
    logic                  smp_vld_i = 1'b0;
    logic [SMP_W-1:0]      smp_i = '0;
    logic                  pix_vld_o;
    logic [IDX_W-1:0]      pix_idx_o;
    logic signed [SMP_W:0] pix_val_o;
    logic                  eol_o;
    logic                  short_o;

    line_pixel_sequencer i_line_pixel_sequencer (
        .clk(clk), .rst(rst), .period_i(period_i), .start_i(start_i),
        .gate_i(gate_i), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
        .pix_vld_o(pix_vld_o), .pix_idx_o(pix_idx_o), .pix_val_o(pix_val_o),
        .eol_o(eol_o), .short_o(short_o)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    string cur_tag = "R1";

    // stimulus values
    bit v_rst = 1, v_period = 0, v_start = 0, v_gate = 1, v_vld = 0;
    int v_smp = 0;

    // reference model state
    int  m_st = 0, m_idx = 1, m_ph = 0, m_ref = 0, m_done = 0;
    bit  m_tp = 0, m_gp = 0;
    bit  e_vld, e_eol, e_short;
    int  e_idx = 0, e_val = 0;

    // per-line tallies
    int n_valid, n_eol, n_short, first_idx, last_idx, vmin, vmax;

    function automatic bit in_band(int i);
        return (i >= 3) && (i <= 514);
    endfunction

    task automatic model_step();
        bit rise, fall;
        e_vld = 0; e_eol = 0; e_short = 0;
        if (v_rst) begin
            m_st = 0; m_idx = 1; m_ph = 0; m_ref = 0; m_done = 0;
            m_tp = 0; m_gp = 0;
            return;
        end
        rise = v_start && !m_tp;
        fall = !v_gate && m_gp;
        case (m_st)
            0: if (rise && v_period) begin
                   m_st = 1; m_idx = 1; m_ph = 0; m_done = 0;
               end
            1: begin
                if (!v_period) begin
                    if (!m_done) begin e_eol = 1; e_short = 1; end
                    m_st = 0;
                end else if (fall) begin
                    if (!m_done) begin e_eol = 1; e_short = 1; end
                    m_st = 2;
                end else if (v_vld) begin
                    if (m_ph == 0) begin m_ref = v_smp; m_ph = 1; end
                    else begin
                        m_ph = 0;
                        if (in_band(m_idx)) begin
                            e_vld = 1; e_idx = m_idx; e_val = v_smp - m_ref;
                        end
                        if (m_idx == 514) begin e_eol = 1; m_done = 1; end
                        if (m_idx == 516) m_st = 2;
                        else m_idx++;
                    end
                end
            end
            default: if (!v_period) m_st = 0;
        endcase
        m_tp = v_start;
        m_gp = v_gate;
    endtask

    task automatic cyc();
        int av;
        rst = v_rst; period_i = v_period; start_i = v_start; gate_i = v_gate;
        smp_vld_i = v_vld; smp_i = SMP_W'(v_smp);
        @(posedge clk);
        model_step();
        #5;
        av = int'(pix_val_o);
        checks++;
        if (pix_vld_o !== e_vld || eol_o !== e_eol || short_o !== e_short ||
            (e_vld && (int'(pix_idx_o) != e_idx || av != e_val))) begin
            errors++;
            $display("FAIL %s: vld/eol/short=%0b%0b%0b idx=%0d val=%0d expected %0b%0b%0b idx=%0d val=%0d",
                     cur_tag, pix_vld_o, eol_o, short_o, pix_idx_o, av,
                     e_vld, e_eol, e_short, e_idx, e_val);
        end
        if (pix_vld_o === 1'b1) begin
            n_valid++;
            if (first_idx < 0) first_idx = int'(pix_idx_o);
            last_idx = int'(pix_idx_o);
            if (av < vmin) vmin = av;
            if (av > vmax) vmax = av;
        end
        if (eol_o === 1'b1) n_eol++;
        if (short_o === 1'b1) n_short++;
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_valid = 0; n_eol = 0; n_short = 0; first_idx = -1; last_idx = -1;
        vmin = 1 << 20; vmax = -(1 << 20);
    endtask

    task automatic start_line();
        clear_counts();
        v_gate = 1; v_period = 1; v_vld = 0; v_start = 0;
        cyc();
        v_start = 1;
        cyc();
        v_start = 0;
    endtask

    // issue nsmp accepted-candidate samples with random idle gaps
    task automatic feed(int nsmp, int mode, bit noise);
        int s = 0;
        while (s < nsmp) begin
            v_vld = ($urandom % 4) != 0;
            v_start = noise ? (($urandom % 8) == 0) : 1'b0;
            if (v_vld) begin
                if (mode == 1) begin
                    int k = s / 2;
                    if (s % 2 == 0) v_smp = (k % 2 == 0) ? 0 : MAXV;
                    else            v_smp = (k % 2 == 0) ? MAXV : 0;
                end else v_smp = int'($urandom % (MAXV + 1));
                s++;
            end
            cyc();
        end
        v_vld = 0; v_start = 0;
    endtask

    task automatic end_period(int n);
        v_period = 0;
        for (int i = 0; i < n; i++) begin
            v_vld = $urandom % 2;
            v_smp = int'($urandom % (MAXV + 1));
            cyc();
        end
        v_vld = 0;
        v_period = 1;
    endtask

    initial begin
        int snap;
        void'($urandom(32'd7741));
        clear_counts();
        // R1: reset state
        cur_tag = "R1";
        v_rst = 1;
        repeat (3) cyc();
        chk(pix_vld_o === 0 && eol_o === 0 && short_o === 0, "R1 reset outputs",
            int'({pix_vld_o, eol_o, short_o}), 0);
        v_rst = 0;

        // R2: samples without a start edge are ignored
        cur_tag = "R2";
        v_period = 1; v_gate = 1;
        clear_counts();
        feed(20, 0, 0);
        chk(n_valid == 0 && n_eol == 0, "R2 no output before start", n_valid + n_eol, 0);

        // R3/R5/R6/R9: full line followed by overrun
        cur_tag = "R5";
        start_line();
        feed(1032, 0, 0);
        snap = n_valid;
        chk(n_valid == 512, "R5 pixel count", n_valid, 512);
        chk(first_idx == 3, "R5 first index", first_idx, 3);
        chk(last_idx == 514, "R5 last index", last_idx, 514);
        chk(n_eol == 1 && n_short == 0, "R6 single normal marker", n_eol * 10 + n_short, 10);
        cur_tag = "R9";
        feed(40, 0, 0);
        chk(n_valid == snap && n_eol == 1, "R9 overrun discarded", n_valid, snap);
        end_period(3);

        // R4: full-scale extremes in both orders
        cur_tag = "R4";
        start_line();
        feed(1032, 1, 0);
        end_period(2);
        chk(vmax == MAXV, "R4 max difference", vmax, MAXV);
        chk(vmin == -MAXV, "R4 min difference", vmin, -MAXV);

        // R10: stray start edges during the read
        cur_tag = "R10";
        start_line();
        feed(1032, 0, 1);
        chk(n_valid == 512 && last_idx == 514, "R10 count with stray starts", n_valid, 512);
        chk(n_eol == 1, "R10 single marker", n_eol, 1);
        end_period(2);

        // R7: period ends with a reference word pending
        cur_tag = "R7";
        start_line();
        feed(201, 0, 0);
        end_period(2);
        chk(n_short == 1 && n_eol == 1, "R7 short marker", n_short, 1);
        chk(n_valid == 98, "R7 partial count", n_valid, 98);
        start_line();
        feed(1032, 0, 0);
        chk(n_valid == 512 && first_idx == 3, "R7 restart at pixel 1", n_valid, 512);
        end_period(2);

        // R8: gate falls mid-line
        cur_tag = "R8";
        start_line();
        feed(600, 0, 0);
        v_gate = 0;
        cyc();
        snap = n_valid;
        feed(50, 0, 0);
        end_period(2);
        chk(n_short == 1, "R8 short marker", n_short, 1);
        chk(snap == 298 && n_valid == 298, "R8 samples after gate dropped", n_valid, 298);

        // R6: line stops after 514 but before 516
        cur_tag = "R6";
        start_line();
        feed(1030, 0, 0);
        end_period(2);
        chk(n_short == 0 && n_eol == 1, "R6 no short after 514", n_short, 0);
        chk(n_valid == 512, "R6 count", n_valid, 512);

        // R1: reset in mid-line
        cur_tag = "R1";
        start_line();
        feed(300, 0, 0);
        v_rst = 1;
        cyc(); cyc();
        chk(pix_vld_o === 0 && eol_o === 0 && short_o === 0, "R1 mid-line reset",
            int'({pix_vld_o, eol_o, short_o}), 0);
        v_rst = 0;
        clear_counts();
        feed(40, 0, 0);
        chk(n_valid == 0 && n_eol == 0, "R1 idle after reset", n_valid, 0);

        // R3: random lengths and endings
        cur_tag = "R3";
        for (int l = 0; l < 4; l++) begin
            start_line();
            feed(int'(100 + $urandom % 1000), 0, 0);
            if ($urandom % 2) begin
                v_gate = 0;
                cyc();
                feed(10, 0, 0);
            end
            end_period(2);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

endmodule